// File: doc/BRIEF.md
# Page-Latched EEPROM Write Engine

This block is a clocked model of the write side of a byte-wide parallel EEPROM with 8192 bytes. It samples active-low chip-enable, write-enable and output-enable strobes and passes them through two-flop synchronizers. It also samples a 13-bit address and an 8-bit data bus. Each completed strobe loads one byte into a 64-byte page register, and a per-byte valid mask records which bytes were loaded. The first load locks the page. Every later accepted load restarts a byte-load window. When the window runs out with no new load, the block enters a self-timed programming period.

During programming, the block walks through the page slots in ascending order, one slot per clock. For each loaded slot it emits one write on an array write port, so the array keeps the unloaded bytes as they were. A busy output covers the programming period. The address and data of the last accepted byte are held on outputs for a read path that can use them for end-of-write polling. The window length and the programming length are parameters in clock cycles.

Top module: `eep_page_writer`

## Requirements
- R1: A load starts only when chip-enable and write-enable are both low, as seen after synchronization, and output-enable is high at the moment both become low. If output-enable is low at that moment, the strobe is ignored and no load, window or programming period results.
- R2: The address is taken when the later of the two enables falls. The data is taken when the first of the two enables rises. Either enable may be the one that pulses.
- R3: Address bits [5:0] select one of 64 slots in the page register, and bits [12:6] select the page. All 64 slots can be loaded and committed in one programming period.
- R4: Each accepted load restarts a window of WIN_CYC cycles. If WIN_CYC cycles pass with no accepted load, programming begins and busy rises.
- R5: Slots may be loaded in any order. Loading the same slot again within one window replaces its data, and the last value is committed.
- R6: In programming cycle k (counting from 0), for k < 64, the array port writes slot k if and only if slot k was loaded. It writes address {page, k} with that slot's data. Slots that were not loaded are never written.
- R7: Busy stays high for exactly PROG_CYC cycles. Strobes that complete while busy is high are ignored.
- R8: A strobe in an open window whose page bits differ from the locked page is ignored. It does not restart the window, and the locked page is committed unchanged.
- R9: last_addr and last_data show the address and data of the most recent accepted load, and they do not change while busy is high.
- R10: After reset, busy and mem_we are low, and last_addr and last_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip-enable, active low, asynchronous |
| we_n | input | 1 | Write-enable, active low, asynchronous |
| oe_n | input | 1 | Output-enable, active low, asynchronous |
| addr | input | 13 | Byte address: page in [12:6], slot in [5:0] |
| din | input | 8 | Write data bus |
| busy | output | 1 | High during the programming period |
| last_addr | output | 13 | Address of the last accepted load |
| last_data | output | 8 | Data of the last accepted load |
| mem_we | output | 1 | Array write strobe during programming |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest case to reach from the ports is the one where the two enables fall and rise in different orders while the address and data buses change between the edges. That case is what shows that the address comes from the later fall and the data from the first rise. The stimulus builds it directly: one enable is held low while the address moves to its final value, the data bus is changed only after the first enable has risen and been synchronized, and the second enable rises after that. A second hard case is a foreign-page strobe or a strobe during busy arriving next to a live window. The bench reaches it by timing a write against busy, and by inserting an off-page byte between two on-page loads.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int SLOT_W = 6;
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int SLOTS  = 1 << SLOT_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [PAGE_W-1:0] page_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} eep_state_t;

  function automatic slot_t slot_of(addr_t a);
    return a[SLOT_W-1:0];
  endfunction

  function automatic page_t page_of(addr_t a);
    return a[ADDR_W-1:SLOT_W];
  endfunction

  function automatic addr_t join_addr(page_t p, slot_t s);
    return {p, s};
  endfunction
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= raw[i];
        sync_q <= meta_q;
      end
    end
    assign synced[i] = sync_q;
  end
endmodule

// File: rtl/eep_strobe.sv
module eep_strobe
  import eep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_ce_n,
  input  logic  s_we_n,
  input  logic  s_oe_n,
  input  addr_t addr,
  input  data_t din,
  output logic  ld_stb,
  output addr_t ld_addr,
  output data_t ld_data
);
  logic  both_low, act_q, armed_q;
  logic  start_ev, end_ev;
  addr_t addr_lat;

  assign both_low = !s_ce_n && !s_we_n;
  // later falling edge: both enables just became low
  assign start_ev = both_low && !act_q;
  // first rising edge: the pair just stopped being low together
  assign end_ev   = !both_low && act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      armed_q  <= 1'b0;
      addr_lat <= '0;
    end else begin
      act_q <= both_low;
      if (start_ev) begin
        armed_q  <= s_oe_n;
        addr_lat <= addr;
      end else if (end_ev) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign ld_stb  = end_ev && armed_q;
  assign ld_addr = addr_lat;
  assign ld_data = din;

  // R1
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !s_oe_n) |=> !ld_stb);
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
  import eep_pkg::*;
#(
  parameter int WIN_CYC  = 100,
  parameter int PROG_CYC = 1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_stb,
  input  addr_t ld_addr,
  input  data_t ld_data,
  output logic  busy,
  output addr_t last_addr,
  output data_t last_data,
  output logic  mem_we,
  output addr_t mem_addr,
  output data_t mem_wdata
);
  localparam int WCNT_W = $clog2(WIN_CYC + 1);
  localparam int PCNT_W = $clog2(PROG_CYC + 1);

  eep_state_t         st;
  page_t              page_q;
  data_t              buf_q [SLOTS];
  logic [SLOTS-1:0]   vld_q;
  logic [WCNT_W-1:0]  wcnt;
  logic [PCNT_W-1:0]  pcnt;

  logic  page_match, ld_hit, win_done, prog_done, in_commit;
  slot_t ld_slot, prog_slot;

  assign ld_slot    = slot_of(ld_addr);
  assign page_match = page_of(ld_addr) == page_q;
  assign ld_hit     = ld_stb && (st == ST_IDLE || (st == ST_LOAD && page_match));
  assign win_done   = (st == ST_LOAD) && !ld_hit && (wcnt == WCNT_W'(WIN_CYC - 1));
  assign prog_done  = (st == ST_PROG) && (pcnt == PCNT_W'(PROG_CYC - 1));
  assign prog_slot  = pcnt[SLOT_W-1:0];
  assign in_commit  = (st == ST_PROG) && (pcnt < PCNT_W'(SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      page_q    <= '0;
      vld_q     <= '0;
      wcnt      <= '0;
      pcnt      <= '0;
      last_addr <= '0;
      last_data <= '0;
    end else if (ld_hit) begin
      vld_q[ld_slot] <= 1'b1;
      wcnt           <= '0;
      last_addr      <= ld_addr;
      last_data      <= ld_data;
      if (st == ST_IDLE) begin
        page_q <= page_of(ld_addr);
        st     <= ST_LOAD;
      end
    end else if (win_done) begin
      st   <= ST_PROG;
      pcnt <= '0;
    end else if (st == ST_LOAD) begin
      wcnt <= wcnt + 1'b1;
    end else if (prog_done) begin
      st    <= ST_IDLE;
      vld_q <= '0;
    end else if (st == ST_PROG) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_hit) buf_q[ld_slot] <= ld_data;
  end

  assign busy      = (st == ST_PROG);
  assign mem_we    = in_commit && vld_q[prog_slot];
  assign mem_addr  = join_addr(page_q, prog_slot);
  assign mem_wdata = buf_q[prog_slot];

  // R6
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R8
  page_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (page_of(mem_addr) == page_of(last_addr)));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_stb) |=> ($stable(last_addr) && $stable(last_data)));
  // R4
  win_to_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> $rose(busy));
  // R7
  prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (!busy && !mem_we));
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
  import eep_pkg::*;
#(
  parameter int WIN_CYC  = 100,
  parameter int PROG_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic [2:0] ctl_sync;
  logic       ld_stb;
  addr_t      ld_addr;
  data_t      ld_data;

  eep_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({oe_n, we_n, ce_n}), .synced(ctl_sync)
  );

  eep_strobe u_strobe (
    .clk(clk), .rst_n(rst_n),
    .s_ce_n(ctl_sync[0]), .s_we_n(ctl_sync[1]), .s_oe_n(ctl_sync[2]),
    .addr(addr), .din(din),
    .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  eep_page_ctrl #(.WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data),
    .busy(busy), .last_addr(last_addr), .last_data(last_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/sim_eep_page_writer.sv
module sim_eep_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 40;
  localparam int PROG = 80;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic busy, mem_we;
  logic [12:0] last_addr, mem_addr;
  logic [7:0]  last_data, mem_wdata;

  eep_page_writer #(.WIN_CYC(WIN), .PROG_CYC(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .busy(busy), .last_addr(last_addr),
    .last_data(last_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, busy_rises = 0, busy_cyc = 0;
  bit busy_prev = 1'b0, done = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // ---------------- behavioural reference ----------------
  bit [2:0] hist[$] = '{3'b111, 3'b111};
  bit m_actq, m_armed;
  int m_alat, m_st, m_page, m_wcnt, m_pcnt, m_last_a, m_last_d;
  int m_buf[64];
  bit m_vld[64];
  byte unsigned dut_mem[int], ref_mem[int];

  function automatic bit m_we();
    return m_st == 2 && m_pcnt < 64 && m_vld[m_pcnt];
  endfunction

  function automatic int dget(int a);
    return dut_mem.exists(a) ? int'(dut_mem[a]) : 255;
  endfunction

  always @(posedge clk) begin : model
    bit [2:0] sy;
    bit act, start, endv, ld, hit;
    if (!rst_n) begin
      hist = '{3'b111, 3'b111};
      m_actq = 0; m_armed = 0; m_alat = 0; m_st = 0; m_page = 0;
      m_wcnt = 0; m_pcnt = 0; m_last_a = 0; m_last_d = 0;
      foreach (m_vld[i]) m_vld[i] = 0;
    end else begin
      sy = hist[1];
      hist.push_front({oe_n, we_n, ce_n});
      void'(hist.pop_back());
      act   = !sy[0] && !sy[1];
      start = act && !m_actq;
      endv  = !act && m_actq;
      ld    = endv && m_armed;
      if (m_we()) ref_mem[m_page * 64 + m_pcnt] = 8'(m_buf[m_pcnt]);
      hit = ld && (m_st == 0 || (m_st == 1 && (m_alat / 64) == m_page));
      if (hit) begin
        m_buf[m_alat % 64] = int'(din);
        m_vld[m_alat % 64] = 1;
        m_wcnt = 0; m_last_a = m_alat; m_last_d = int'(din);
        if (m_st == 0) begin m_page = m_alat / 64; m_st = 1; end
      end else if (m_st == 1) begin
        if (m_wcnt == WIN - 1) begin m_st = 2; m_pcnt = 0; end
        else m_wcnt++;
      end else if (m_st == 2) begin
        if (m_pcnt == PROG - 1) begin
          m_st = 0;
          foreach (m_vld[i]) m_vld[i] = 0;
        end else m_pcnt++;
      end
      if (start) begin m_armed = sy[2]; m_alat = int'(addr); end
      else if (endv) m_armed = 0;
      m_actq = act;
    end
  end

  always @(posedge clk) if (rst_n && mem_we) dut_mem[int'(mem_addr)] = mem_wdata;

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy == (m_st == 2), "R7", "busy", busy, m_st == 2);
      chk(int'(last_addr) == m_last_a, "R9", "last_addr", last_addr, m_last_a);
      chk(int'(last_data) == m_last_d, "R9", "last_data", last_data, m_last_d);
      chk(mem_we == m_we(), "R6", "mem_we", mem_we, m_we());
      if (mem_we && m_we()) begin
        chk(int'(mem_addr) == m_page * 64 + m_pcnt, "R6", "mem_addr", mem_addr, m_page * 64 + m_pcnt);
        chk(int'(mem_wdata) == m_buf[m_pcnt], "R6", "mem_wdata", mem_wdata, m_buf[m_pcnt]);
      end
      if (busy && !busy_prev) busy_rises++;
      if (busy) busy_cyc++;
      busy_prev = busy;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, int d, bit ce_pulse, bit oe_high);
    @(negedge clk);
    addr = 13'(a); din = 8'(d); oe_n = oe_high;
    if (!ce_pulse) begin ce_n = 0; repeat (3) @(negedge clk); we_n = 0; end
    else begin we_n = 0; repeat (3) @(negedge clk); ce_n = 0; end
    repeat (4) @(negedge clk);
    if (!ce_pulse) we_n = 1; else ce_n = 1;
    repeat (5) @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    repeat (WIN + PROG + 10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    report();
  end

  initial begin
    int r0, c0, la;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0, "R10", "busy", busy, 0);
    chk(mem_we == 0, "R10", "mem_we", mem_we, 0);
    chk(last_addr == 0 && last_data == 0, "R10", "last", last_addr, 0);

    // R6 single byte, then R7 programming length
    c0 = busy_cyc;
    wr(13'h0C5, 8'h3C, 0, 1); settle();
    chk(dget(13'h0C5) == 8'h3C, "R6", "byte", dget(13'h0C5), 8'h3C);
    chk(dget(13'h0C4) == 255, "R6", "neighbour", dget(13'h0C4), 255);
    chk(busy_cyc - c0 == PROG, "R7", "busy length", busy_cyc - c0, PROG);

    // R5 / R6: preload slot 5 of page 3, then reorder and overwrite
    wr(3*64+5, 8'h55, 0, 1); settle();
    wr(3*64+7, 8'hA1, 0, 1); wr(3*64+2, 8'hB2, 1, 1); wr(3*64+7, 8'hC3, 0, 1); settle();
    chk(dget(3*64+7) == 8'hC3, "R5", "rewrite", dget(3*64+7), 8'hC3);
    chk(dget(3*64+2) == 8'hB2, "R5", "order", dget(3*64+2), 8'hB2);
    chk(dget(3*64+5) == 8'h55, "R6", "unloaded kept", dget(3*64+5), 8'h55);

    // R1 strobe with output-enable low is ignored
    r0 = busy_rises; la = int'(last_addr);
    wr(13'h1234, 8'h99, 0, 0); settle();
    chk(busy_rises == r0, "R1", "no programming", busy_rises - r0, 0);
    chk(int'(last_addr) == la, "R1", "last_addr", last_addr, la);
    chk(dget(13'h1234) == 255, "R1", "array", dget(13'h1234), 255);

    // R2 address at later fall, data at first rise
    @(negedge clk); addr = 13'h0801; din = 8'h11; we_n = 0;
    repeat (4) @(negedge clk); addr = 13'h0842; ce_n = 0;
    repeat (5) @(negedge clk); ce_n = 1;
    repeat (6) @(negedge clk); din = 8'hEE;
    repeat (2) @(negedge clk); we_n = 1;
    repeat (4) @(negedge clk);
    chk(last_addr == 13'h0842, "R2", "addr", last_addr, 13'h0842);
    chk(last_data == 8'h11, "R2", "data", last_data, 8'h11);
    settle();
    chk(dget(13'h0842) == 8'h11, "R2", "array", dget(13'h0842), 8'h11);
    chk(dget(13'h0801) == 255, "R2", "early addr", dget(13'h0801), 255);

    // R8 foreign page inside a window
    r0 = busy_rises;
    wr(20*64+1, 8'h21, 0, 1); wr(21*64+1, 8'h77, 0, 1); wr(20*64+9, 8'h29, 0, 1); settle();
    chk(dget(21*64+1) == 255, "R8", "foreign page", dget(21*64+1), 255);
    chk(dget(20*64+9) == 8'h29, "R8", "locked page", dget(20*64+9), 8'h29);
    chk(busy_rises - r0 == 1, "R8", "one period", busy_rises - r0, 1);

    // R7 strobe while busy is ignored
    r0 = busy_rises;
    wr(30*64, 8'h30, 0, 1);
    wait (busy);
    la = int'(last_addr);
    wr(31*64, 8'h31, 0, 1);
    chk(int'(last_addr) == la, "R7", "last_addr while busy", last_addr, la);
    settle();
    chk(dget(31*64) == 255, "R7", "ignored byte", dget(31*64), 255);
    chk(busy_rises - r0 == 1, "R7", "periods", busy_rises - r0, 1);

    // R4 window restart vs expiry
    r0 = busy_rises;
    wr(40*64, 1, 0, 1); repeat (WIN - 20) @(negedge clk); wr(40*64+1, 2, 0, 1); settle();
    chk(busy_rises - r0 == 1, "R4", "within window", busy_rises - r0, 1);
    r0 = busy_rises;
    wr(41*64, 3, 0, 1); repeat (WIN + PROG + 5) @(negedge clk); wr(41*64+1, 4, 0, 1); settle();
    chk(busy_rises - r0 == 2, "R4", "window expired", busy_rises - r0, 2);

    // R3 full page in scrambled order
    r0 = busy_rises;
    for (int s = 0; s < 64; s++) wr(9*64 + (s ^ 21), (s ^ 21) * 3 + 1, s[0], 1);
    settle();
    chk(busy_rises - r0 == 1, "R3", "single period", busy_rises - r0, 1);
    chk(dget(9*64+63) == 63*3+1, "R3", "slot 63", dget(9*64+63), 63*3+1);
    chk(dget(9*64) == 1, "R3", "slot 0", dget(9*64), 1);

    // whole-array comparison against the reference
    done = 1;
    chk(dut_mem.num() == ref_mem.num(), "R6", "written count", dut_mem.num(), ref_mem.num());
    foreach (ref_mem[a]) chk(dget(a) == int'(ref_mem[a]), "R6", "array byte", dget(a), ref_mem[a]);
    report();
  end
endmodule